// File: doc/BRIEF.md
# Disk Byte Read Buffer with Status Word

This block holds the most recent byte from a disk read path so that a processor can fetch it. It returns that byte in one 16-bit read word, together with status flags. When the read path presents a byte with a strobe, the block stores the byte and raises a byte-ready flag. A processor read lowers the flag on the following clock edge, so a polling loop sees each byte once.

The other three flags in the word are live views of inputs. The DMA-active flag is high when both the disk-channel DMA enable and the global DMA master enable are high. The write-mode flag follows the disk channel's write-direction bit. The word-match flag is high only while the incoming 16-bit disk word equals the programmed sync word. The serializer that assembles bytes and the DMA engine lie outside this block.

Top module: `disk_byte_status`

## Requirements
- R1: One clock edge after a cycle with `byte_stb` high, bits 7..0 of `rd_data` hold the strobed `byte_in`, and bit 15 (byte ready) is 1.
- R2: A cycle with `rd_stb` high and `byte_stb` low still shows bit 15 as it stood before that cycle. Bit 15 reads 0 from the next clock edge.
- R3: Bit 14 of `rd_data` is `disk_dma_en` AND `dma_master_en`, in the same cycle.
- R4: Bit 13 of `rd_data` equals `write_mode`, in the same cycle.
- R5: Bit 12 of `rd_data` is 1 exactly while `disk_word` equals `sync_word`, with no clock delay.
- R6: Bits 11..8 of `rd_data` always read 0.
- R7: When `byte_stb` and `rd_stb` are high in the same cycle, the new byte is stored and bit 15 stays 1 after the edge.
- R8: While `rst_n` is low, bit 15 and bits 7..0 read 0.
- R9: In a cycle with neither strobe high, the stored byte and bit 15 keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_stb | input | 1 | A byte from the read path is valid this cycle |
| byte_in | input | 8 | Byte from the read path |
| disk_word | input | SYNC_W | Current word from the disk data stream |
| sync_word | input | SYNC_W | Programmed sync word |
| disk_dma_en | input | 1 | Disk-channel DMA enable |
| dma_master_en | input | 1 | Global DMA master enable |
| write_mode | input | 1 | Disk channel is set to write |
| rd_stb | input | 1 | Processor reads the status word this cycle |
| rd_data | output | 16 | Status word: {ready, dma active, write mode, match, 4'b0, byte} |

## Verification
The stored byte and the ready flag change one edge after a strobe. The bench drives each strobe on a falling edge and checks the result on the next falling edge, one rising edge later. The DMA-active, write-mode, match and unused bits depend on no clock. They are checked a small delay after their inputs change, inside the same cycle. For a read, the bench samples the word during the read cycle to confirm that the flag has not yet cleared, then checks again on the following falling edge to confirm the clear. In the collision case, the bench samples once in the strobe cycle and once after the edge.

// File: rtl/disk_byte_status.sv
module disk_byte_status #(
  parameter int SYNC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic [7:0]        byte_in,
  input  logic [SYNC_W-1:0] disk_word,
  input  logic [SYNC_W-1:0] sync_word,
  input  logic              disk_dma_en,
  input  logic              dma_master_en,
  input  logic              write_mode,
  input  logic              rd_stb,
  output logic [15:0]       rd_data
);

  logic       ready_q;
  logic [7:0] byte_q;
  logic       dma_on;
  logic       match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      byte_q  <= '0;
    end else if (byte_stb) begin
      ready_q <= 1'b1;
      byte_q  <= byte_in;
    end else if (rd_stb) begin
      ready_q <= 1'b0;
    end
  end

  assign dma_on  = disk_dma_en & dma_master_en;
  assign match   = (disk_word == sync_word);
  assign rd_data = {ready_q, dma_on, write_mode, match, 4'b0000, byte_q};

  p_load_sets_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> (rd_data[15] && rd_data[7:0] == $past(byte_in)));

  p_read_clears_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !byte_stb) |=> !rd_data[15]);

  p_collision_keeps_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && byte_stb) |=> rd_data[15]);

  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !byte_stb) |=> ($stable(rd_data[15]) && $stable(rd_data[7:0])));

endmodule

// File: tb/tb_disk_byte_status.sv
module tb_disk_byte_status;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_stb = 1'b0;
  logic [7:0]  byte_in = '0;
  logic [15:0] disk_word = 16'h0000;
  logic [15:0] sync_word = 16'h4489;
  logic        disk_dma_en = 1'b0;
  logic        dma_master_en = 1'b0;
  logic        write_mode = 1'b0;
  logic        rd_stb = 1'b0;
  logic [15:0] rd_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  disk_byte_status #(.SYNC_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_in(byte_in),
    .disk_word(disk_word), .sync_word(sync_word), .disk_dma_en(disk_dma_en),
    .dma_master_en(dma_master_en), .write_mode(write_mode), .rd_stb(rd_stb),
    .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_byte(input logic [7:0] b);
    @(negedge clk);
    byte_stb = 1'b1; byte_in = b;
    @(negedge clk);
    byte_stb = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    check("R8 ready in reset", {15'b0, rd_data[15]}, 16'h0);
    check("R8 byte in reset", {8'b0, rd_data[7:0]}, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R8 after reset release", {rd_data[15], 7'b0, rd_data[7:0]}, 16'h0);
  endtask

  task automatic t_load;
    load_byte(8'hA5);
    check("R1 ready after load", {15'b0, rd_data[15]}, 16'h1);
    check("R1 byte after load", {8'b0, rd_data[7:0]}, 16'h00A5);
    load_byte(8'h5A);
    check("R1 second byte overwrites", {8'b0, rd_data[7:0]}, 16'h005A);
  endtask

  task automatic t_read;
    @(negedge clk);
    rd_stb = 1'b1;
    #1;
    check("R2 ready visible in read cycle", {15'b0, rd_data[15]}, 16'h1);
    @(negedge clk);
    rd_stb = 1'b0;
    check("R2 ready cleared after read", {15'b0, rd_data[15]}, 16'h0);
    check("R2 byte kept after read", {8'b0, rd_data[7:0]}, 16'h005A);
  endtask

  task automatic t_collide;
    @(negedge clk);
    byte_stb = 1'b1; byte_in = 8'hC3; rd_stb = 1'b1;
    #1;
    check("R7 old ready seen in collision cycle", {15'b0, rd_data[15]}, 16'h0);
    @(negedge clk);
    byte_stb = 1'b0; rd_stb = 1'b0;
    check("R7 ready set after collision", {15'b0, rd_data[15]}, 16'h1);
    check("R7 byte loaded in collision", {8'b0, rd_data[7:0]}, 16'h00C3);
    @(negedge clk);
    byte_stb = 1'b1; byte_in = 8'h3C; rd_stb = 1'b1;
    @(negedge clk);
    byte_stb = 1'b0; rd_stb = 1'b0;
    check("R7 ready stays set when already set", {15'b0, rd_data[15]}, 16'h1);
    check("R7 second collision byte", {8'b0, rd_data[7:0]}, 16'h003C);
  endtask

  task automatic t_hold;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9 idle hold", {rd_data[15], 7'b0, rd_data[7:0]}, 16'h803C);
    end
  endtask

  task automatic t_flags;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      disk_dma_en = k[0]; dma_master_en = k[1];
      #1;
      check("R3 dma active flag", {15'b0, rd_data[14]}, {15'b0, k[0] & k[1]});
    end
    write_mode = 1'b1; #1;
    check("R4 write mode high", {15'b0, rd_data[13]}, 16'h1);
    write_mode = 1'b0; #1;
    check("R4 write mode low", {15'b0, rd_data[13]}, 16'h0);
    disk_word = 16'h4489; #1;
    check("R5 match true", {15'b0, rd_data[12]}, 16'h1);
    disk_word = 16'h4488; #1;
    check("R5 match false", {15'b0, rd_data[12]}, 16'h0);
    sync_word = 16'h4488; #1;
    check("R5 match follows sync change", {15'b0, rd_data[12]}, 16'h1);
    disk_word = 16'hFFFF; write_mode = 1'b1; disk_dma_en = 1'b1; dma_master_en = 1'b1; #1;
    check("R6 unused bits zero", {12'b0, rd_data[11:8]}, 16'h0);
    check("R9 byte unaffected by flags", {8'b0, rd_data[7:0]}, 16'h003C);
  endtask

  initial begin
    t_reset();
    t_load();
    t_read();
    t_collide();
    t_hold();
    t_flags();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule